// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This block evaluates one relational or selection operation per clock on a pair of IEEE-754 operands, in either single or double precision. The relational operations (equal, less-than, less-or-equal) yield a single bit that a core writes into an integer register as 0 or 1. The selection operations (minimum, maximum) yield a 64-bit floating-point result. Every operation also yields a 5-bit exception flag vector in which only the invalid-operation bit can ever be set.

No floating-point arithmetic is involved. Each operand is split into sign, magnitude and NaN/zero classification, and ordering comes from comparing sign-magnitude encodings. The block handles signed zeros, the quiet and signaling NaN cases, and the canonical NaN exactly. Results are registered, so they appear one clock after the inputs are presented.

Top module: `fpcmp_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it rises, `cmp_out`, `res_out` and `flags_out` are all zero. Otherwise the outputs reflect the inputs sampled at the previous rising edge, with one cycle of latency.
- R2: `op_sel` encodings are 0 equal, 1 less-than, 2 less-or-equal, 3 minimum and 4 maximum. Codes 5 to 7 drive all outputs to zero. With `prec_dbl`=1 the full 64-bit operands are used. With `prec_dbl`=0 only bits 31:0 are used and bits 63:32 of the inputs have no effect.
- R3: Equal returns 1 only for numerically equal operands, treating +0 and -0 as equal, and returns 0 if either operand is a NaN. It sets NV only when an operand is a signaling NaN (exponent all ones, nonzero fraction, fraction MSB clear).
- R4: Less-than returns 1 when operand A is strictly below operand B. Less-or-equal returns 1 when A is below or equal to B. Both return 0 and set NV when either operand is any NaN.
- R5: Ordering is numeric across signs, infinities and subnormals: a negative operand with the larger magnitude is the smaller value, and +0 and -0 are equal.
- R6: Minimum returns the bit pattern of the smaller operand. When the operands are +0 and -0, in either order, it returns -0.
- R7: Maximum returns the bit pattern of the larger operand. When the operands are +0 and -0, in either order, it returns +0.
- R8: If exactly one min/max operand is a NaN, the other operand is returned. If both are NaN, the canonical NaN is returned: 0x7FF8000000000000 in double mode, 0x000000007FC00000 in single mode.
- R9: Minimum and maximum set NV only when an operand is a signaling NaN. Quiet NaNs raise no flag.
- R10: `flags_out` bit 4 is NV. Bits 3:0 (divide-by-zero, overflow, underflow, inexact) are always 0. `cmp_out` is 0 for min/max operations, and `res_out` is 0 for compare operations.
- R11: In single mode the min/max result is the 32-bit pattern zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prec_dbl | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| op_sel | input | 3 | Operation code (see R2) |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| cmp_out | output | 1 | Registered compare result |
| res_out | output | 64 | Registered min/max result |
| flags_out | output | 5 | Registered exception flags, NV in bit 4 |

## Verification
The block holds no state apart from its output register, so any wrong internal value appears at the ports on the edge right after the offending inputs. A bad classification shows as a wrong NV bit or a wrong NaN substitution. A bad ordering shows as a flipped compare bit or as the wrong operand picked for min/max. The signed-zero tie-break shows only in the sign bit of `res_out`. The bench therefore compares every output bit against a numeric reference on every cycle, using directed signed-zero, NaN and subnormal cases plus mixed special values.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int DW      = 64;
    localparam int MAG_W   = DW - 1;
    localparam int FLAGS_W = 5;
    localparam int FLG_NV  = 4;

    localparam int SGL_EXP_W = 8;
    localparam int SGL_MAN_W = 23;
    localparam int DBL_EXP_W = 11;
    localparam int DBL_MAN_W = 52;

    localparam logic [DW-1:0] CANON_DBL = 64'h7FF8_0000_0000_0000;
    localparam logic [DW-1:0] CANON_SGL = 64'h0000_0000_7FC0_0000;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_LT  = 3'd1,
        OP_LE  = 3'd2,
        OP_MIN = 3'd3,
        OP_MAX = 3'd4
    } fpc_op_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
        logic [DW-1:0]    raw;
    } fpc_opnd_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic unord;
    } fpc_order_t;

    typedef struct packed {
        logic               cmp;
        logic [DW-1:0]      res;
        logic [FLAGS_W-1:0] flags;
    } fpc_result_t;

    function automatic logic [DW-1:0] canon_nan(input logic dbl);
        return dbl ? CANON_DBL : CANON_SGL;
    endfunction

endpackage

// File: rtl/fpc_fmt_decode.sv
module fpc_fmt_decode
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] bits,
    output fpc_opnd_t            d
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = bits[W-2:MAN_W];
    assign man_f = bits[MAN_W-1:0];

    always_comb begin
        d      = '0;
        d.sign = bits[W-1];
        d.nan  = (&exp_f) && (|man_f);
        d.snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
        d.zero = ~|bits[W-2:0];
        d.mag  = MAG_W'(bits[W-2:0]);
        d.raw  = DW'(bits);
    end
endmodule

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpcmp_pkg::*;
(
    input  logic          prec_dbl,
    input  logic [DW-1:0] raw,
    output fpc_opnd_t     d
);
    fpc_opnd_t d_sgl, d_dbl;

    fpc_fmt_decode #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) u_sgl (
        .bits (raw[SGL_EXP_W+SGL_MAN_W:0]),
        .d    (d_sgl)
    );

    fpc_fmt_decode #(.EXP_W(DBL_EXP_W), .MAN_W(DBL_MAN_W)) u_dbl (
        .bits (raw[DBL_EXP_W+DBL_MAN_W:0]),
        .d    (d_dbl)
    );

    assign d = prec_dbl ? d_dbl : d_sgl;
endmodule

// File: rtl/fpc_order.sv
module fpc_order
    import fpcmp_pkg::*;
(
    input  fpc_opnd_t  a,
    input  fpc_opnd_t  b,
    output fpc_order_t ord
);
    logic unord, both_zero, same, lt_raw;

    always_comb begin
        unord     = a.nan | b.nan;
        both_zero = a.zero & b.zero;
        same      = (a.sign == b.sign) && (a.mag == b.mag);
        if (both_zero)
            lt_raw = 1'b0;
        else if (a.sign != b.sign)
            lt_raw = a.sign;
        else if (a.sign)
            lt_raw = a.mag > b.mag;
        else
            lt_raw = a.mag < b.mag;

        ord.unord = unord;
        ord.eq    = !unord && (both_zero || same);
        ord.lt    = !unord && lt_raw;
        ord.gt    = !unord && !lt_raw && !(both_zero || same);
    end
endmodule

// File: rtl/fpc_select.sv
module fpc_select
    import fpcmp_pkg::*;
(
    input  logic        prec_dbl,
    input  logic [2:0]  op_sel,
    input  fpc_opnd_t   a,
    input  fpc_opnd_t   b,
    input  fpc_order_t  ord,
    output fpc_result_t r
);
    logic any_snan;

    always_comb begin
        any_snan = a.snan | b.snan;
        r        = '0;
        case (op_sel)
            OP_EQ: begin
                r.cmp           = ord.eq;
                r.flags[FLG_NV] = any_snan;
            end
            OP_LT: begin
                r.cmp           = ord.lt;
                r.flags[FLG_NV] = ord.unord;
            end
            OP_LE: begin
                r.cmp           = ord.lt | ord.eq;
                r.flags[FLG_NV] = ord.unord;
            end
            OP_MIN: begin
                r.flags[FLG_NV] = any_snan;
                if (a.nan && b.nan)  r.res = canon_nan(prec_dbl);
                else if (a.nan)      r.res = b.raw;
                else if (b.nan)      r.res = a.raw;
                else if (ord.lt)     r.res = a.raw;
                else if (ord.gt)     r.res = b.raw;
                else                 r.res = a.sign ? a.raw : b.raw;
            end
            OP_MAX: begin
                r.flags[FLG_NV] = any_snan;
                if (a.nan && b.nan)  r.res = canon_nan(prec_dbl);
                else if (a.nan)      r.res = b.raw;
                else if (b.nan)      r.res = a.raw;
                else if (ord.gt)     r.res = a.raw;
                else if (ord.lt)     r.res = b.raw;
                else                 r.res = a.sign ? b.raw : a.raw;
            end
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prec_dbl,
    input  logic [2:0]         op_sel,
    input  logic [DW-1:0]      opa,
    input  logic [DW-1:0]      opb,
    output logic               cmp_out,
    output logic [DW-1:0]      res_out,
    output logic [FLAGS_W-1:0] flags_out
);
    localparam int N_OPND = 2;

    logic [DW-1:0] opnd_raw [N_OPND];
    fpc_opnd_t     opnd     [N_OPND];
    fpc_order_t    ord;
    fpc_result_t   res_d, res_q;

    assign opnd_raw[0] = opa;
    assign opnd_raw[1] = opb;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_unpack
        fpc_unpack u_unpack (
            .prec_dbl (prec_dbl),
            .raw      (opnd_raw[gi]),
            .d        (opnd[gi])
        );
    end

    fpc_order u_order (
        .a   (opnd[0]),
        .b   (opnd[1]),
        .ord (ord)
    );

    fpc_select u_select (
        .prec_dbl (prec_dbl),
        .op_sel   (op_sel),
        .a        (opnd[0]),
        .b        (opnd[1]),
        .ord      (ord),
        .r        (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign cmp_out   = res_q.cmp;
    assign res_out   = res_q.res;
    assign flags_out = res_q.flags;
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        prec_dbl,
    input logic [2:0]  op_sel,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        cmp_out,
    input logic [63:0] res_out,
    input logic [4:0]  flags_out
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cmp_out == 1'b0 && res_out == 64'd0 && flags_out == 5'd0));

    // R10
    a_r10_flags_only_nv: assert property (@(posedge clk) disable iff (rst)
        live |-> flags_out[3:0] == 4'd0);

    a_r10_cmp_res_exclusive: assert property (@(posedge clk) disable iff (rst)
        (live && cmp_out) |-> res_out == 64'd0);

    // R2
    a_r2_bad_op_idle: assert property (@(posedge clk) disable iff (rst)
        (live && $past(op_sel) > 3'd4) |->
            (cmp_out == 1'b0 && res_out == 64'd0 && flags_out == 5'd0));

    // R11
    a_r11_single_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(prec_dbl) && ($past(op_sel) == 3'd3 || $past(op_sel) == 3'd4))
            |-> res_out[63:32] == 32'd0);

    // R4
    a_r4_le_self: assert property (@(posedge clk) disable iff (rst)
        (live && $past(prec_dbl) && $past(op_sel) == 3'd2 && $past(opa) == $past(opb)
            && $past(opa[62:52]) != 11'h7FF) |-> cmp_out);
endmodule

bind fpcmp_unit fpcmp_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prec_dbl  (prec_dbl),
    .op_sel    (op_sel),
    .opa       (opa),
    .opb       (opb),
    .cmp_out   (cmp_out),
    .res_out   (res_out),
    .flags_out (flags_out)
);

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prec_dbl = 1'b1;
    logic [2:0]  op_sel = 3'd3;
    logic [63:0] opa = 64'h3FF0_0000_0000_0000;
    logic [63:0] opb = 64'h4000_0000_0000_0000;
    logic        cmp_out;
    logic [63:0] res_out;
    logic [4:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic        cmp;
        logic [63:0] res;
        logic [4:0]  fl;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    fpcmp_unit uut (
        .clk(clk), .rst(rst), .prec_dbl(prec_dbl), .op_sel(op_sel),
        .opa(opa), .opb(opb), .cmp_out(cmp_out), .res_out(res_out),
        .flags_out(flags_out)
    );

    function automatic real sgl_to_real(input logic [31:0] s);
        int  e;
        real m;
        real v;
        if (s[30:23] == 8'hFF)
            return $bitstoreal(s[31] ? 64'hFFF0_0000_0000_0000 : 64'h7FF0_0000_0000_0000);
        e = (s[30:23] == 8'd0) ? 1 : int'(s[30:23]);
        m = (s[30:23] == 8'd0) ? real'(s[22:0]) : real'({1'b1, s[22:0]});
        v = m * (2.0 ** (e - 150));
        return s[31] ? -v : v;
    endfunction

    function automatic exp_t model(input logic dbl, input logic [2:0] op,
                                   input logic [63:0] a, input logic [63:0] b);
        exp_t        x;
        logic        an, bn, asn, bsn, asg;
        real         ra, rb;
        logic [63:0] av, bv;
        x = '0;
        if (dbl) begin
            an  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            bn  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            asn = an && !a[51];
            bsn = bn && !b[51];
            asg = a[63];
            ra  = an ? 0.0 : $bitstoreal(a);
            rb  = bn ? 0.0 : $bitstoreal(b);
            av  = a; bv = b;
        end else begin
            an  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            bn  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            asn = an && !a[22];
            bsn = bn && !b[22];
            asg = a[31];
            ra  = sgl_to_real(a[31:0]);
            rb  = sgl_to_real(b[31:0]);
            av  = {32'd0, a[31:0]}; bv = {32'd0, b[31:0]};
        end
        case (op)
            3'd0: begin x.cmp = !(an || bn) && (ra == rb); x.fl[4] = asn || bsn; end
            3'd1: begin x.cmp = !(an || bn) && (ra <  rb); x.fl[4] = an || bn; end
            3'd2: begin x.cmp = !(an || bn) && (ra <= rb); x.fl[4] = an || bn; end
            3'd3, 3'd4: begin
                x.fl[4] = asn || bsn;
                if (an && bn)     x.res = dbl ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
                else if (an)      x.res = bv;
                else if (bn)      x.res = av;
                else if (ra < rb) x.res = (op == 3'd3) ? av : bv;
                else if (rb < ra) x.res = (op == 3'd3) ? bv : av;
                else if (op == 3'd3) x.res = asg ? av : bv;
                else              x.res = asg ? bv : av;
            end
            default: x = '0;
        endcase
        return x;
    endfunction

    task automatic check_front();
        exp_t  e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (cmp_out !== e.cmp || res_out !== e.res || flags_out !== e.fl) begin
            n_fail++;
            $display("FAIL %s: got cmp=%0b res=%h fl=%b, expected cmp=%0b res=%h fl=%b",
                     t, cmp_out, res_out, flags_out, e.cmp, e.res, e.fl);
        end
    endtask

    // One vector per cycle: check the previous vector's result, then drive a new one.
    task automatic apply(input logic dbl, input logic [2:0] op,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        check_front();
        prec_dbl = dbl; op_sel = op; opa = a; opb = b;
        exp_q.push_back(model(dbl, op, a, b));
        tag_q.push_back(tag);
    endtask

    function automatic logic [63:0] pick(input logic dbl);
        logic [63:0] dp [12];
        logic [31:0] sp [12];
        int          k;
        dp = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
               64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h7FF0_0000_0000_0000,
               64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0000, 64'h7FF4_0000_0000_0000,
               64'h1, 64'h7FEF_FFFF_FFFF_FFFF};
        sp = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'hC000_0000,
               32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'h7FA0_0000, 32'h1, 32'h7F7F_FFFF};
        k = int'($urandom_range(0, 15));
        if (k >= 12) return {$urandom(), $urandom()};
        return dbl ? dp[k] : {$urandom(), sp[k]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (cmp_out !== 1'b0 || res_out !== 64'd0 || flags_out !== 5'd0) begin
            n_fail++;
            $display("FAIL R1 reset: got cmp=%0b res=%h fl=%b, expected all zero",
                     cmp_out, res_out, flags_out);
        end
        rst = 1'b0;

        apply(1, 3'd0, 64'h0, 64'h8000_0000_0000_0000, "R3 eq +0 -0");
        apply(1, 3'd0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R3 eq equal");
        apply(1, 3'd0, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, "R3 eq qnan");
        apply(1, 3'd0, 64'h7FF4_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R3 eq snan");
        apply(1, 3'd1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R4 lt 1<2");
        apply(1, 3'd2, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, "R4 le 2<=2");
        apply(1, 3'd1, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, "R4 lt 2<2");
        apply(1, 3'd2, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R4 le qnan");
        apply(0, 3'd1, 64'h0000_0000_7FA0_0000, 64'h0000_0000_3F80_0000, "R4 lt single snan");
        apply(1, 3'd1, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R5 lt -2<-1");
        apply(1, 3'd1, 64'hBFF0_0000_0000_0000, 64'h0, "R5 lt -1<+0");
        apply(0, 3'd1, 64'h0000_0000_FF80_0000, 64'h0000_0000_7F80_0000, "R5 lt -inf<+inf");
        apply(1, 3'd1, 64'h0, 64'h1, "R5 lt +0<subnormal");
        apply(1, 3'd2, 64'h8000_0000_0000_0000, 64'h0, "R5 le -0<=+0");
        apply(1, 3'd3, 64'h8000_0000_0000_0000, 64'h0, "R6 min -0 +0");
        apply(1, 3'd3, 64'h0, 64'h8000_0000_0000_0000, "R6 min +0 -0");
        apply(1, 3'd3, 64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R6 min 1 -1");
        apply(1, 3'd4, 64'h0, 64'h8000_0000_0000_0000, "R7 max +0 -0");
        apply(1, 3'd4, 64'h8000_0000_0000_0000, 64'h0, "R7 max -0 +0");
        apply(0, 3'd4, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, "R7 max single");
        apply(1, 3'd3, 64'h7FF8_0000_0000_0000, 64'h4014_0000_0000_0000, "R8 min qnan 5");
        apply(0, 3'd4, 64'h0000_0000_3F80_0000, 64'h0000_0000_7FC0_0000, "R8 max one nan");
        apply(1, 3'd3, 64'h7FF8_0000_0000_0001, 64'hFFF4_0000_0000_0000, "R8 min both nan");
        apply(0, 3'd4, 64'h0000_0000_FFC0_0001, 64'h0000_0000_7FA0_0000, "R8 max both nan single");
        apply(1, 3'd4, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R9 max qnan no nv");
        apply(0, 3'd3, 64'h0000_0000_7FA0_0000, 64'h0000_0000_3F80_0000, "R9 min snan nv");
        apply(1, 3'd5, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R2 op 5 idle");
        apply(1, 3'd7, 64'h7FF4_0000_0000_0000, 64'h0, "R2 op 7 idle");
        apply(0, 3'd0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, "R2 upper bits ignored");
        apply(0, 3'd3, 64'hFFFF_FFFF_BF80_0000, 64'hAAAA_AAAA_3F80_0000, "R11 zero extend");
        apply(1, 3'd3, 64'h7FF4_0000_0000_0000, 64'h7FF8_0000_0000_0000, "R10 min no cmp");

        for (int i = 0; i < 800; i++) begin
            logic        d;
            logic [2:0]  o;
            d = 1'($urandom_range(0, 1));
            o = 3'($urandom_range(0, 5));
            case (o)
                3'd0:       apply(d, o, pick(d), pick(d), "R3 mixed");
                3'd1, 3'd2: apply(d, o, pick(d), pick(d), "R4 mixed");
                3'd3:       apply(d, o, pick(d), pick(d), "R6 mixed");
                3'd4:       apply(d, o, pick(d), pick(d), "R7 mixed");
                default:    apply(d, o, pick(d), pick(d), "R10 mixed");
            endcase
        end
        @(negedge clk);
        check_front();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of vectors");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule